// File: doc/BRIEF.md
# GPIO Data and Direction Register Bank

This block is the register bank for sixteen general-purpose pins. Software reaches it over a simple single-cycle bus: an address, a write enable, write data, and read data that follows the address in the same cycle. Each pin has a direction bit and an output data bit. Two write-only-ones aliases set or clear chosen output bits without a read-modify-write. A read-only view returns the pin levels after they have been synchronized.

On the pad side the block drives an output value vector and an output enable vector, and it samples a pin input vector. A direction bit of 1 makes the pin an input. Every direction bit resets to 1, so no pin drives until software turns it into an output. Pin multiplexing, edge interrupts and the pad cell sit outside this block.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, every direction bit is 1, the output data register is 0, and every output enable is 0.
- R2: Offset 0x10 holds the direction bits, read/write. A bit of 1 marks an input and a bit of 0 marks an output. Each pin's output enable is the inverse of its direction bit, and it changes on the clock edge that takes the write.
- R3: Offset 0x14 holds the output data, read/write. A read returns the register contents, not the pin level. The output value vector carries the register contents.
- R4: Writing to offset 0x18 sets each output data bit whose write data bit is 1. Bits written as 0 keep their value.
- R5: Writing to offset 0x1C clears each output data bit whose write data bit is 1. Bits written as 0 keep their value.
- R6: A read of offset 0x18 or offset 0x1C returns the current output data contents.
- R7: Offset 0x20 is read-only and returns the pin levels whatever the direction and output data settings. A pin change applied before a clock edge appears in a read after the second following edge.
- R8: While a pin's direction bit is 1, writes to offsets 0x14, 0x18 and 0x1C leave its output enable at 0.
- R9: Only bits 15:0 of each register exist. Bits 31:16 read as 0, and write data in those bits is ignored.
- R10: A read of any byte offset other than 0x10, 0x14, 0x18, 0x1C and 0x20 returns 0. A write to such an offset, or to offset 0x20, changes neither the direction nor the output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the register |
| wr_en_i | input | 1 | Write strobe, taken at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| pad_out_o | output | 16 | Output value to the pads |
| pad_oe_o | output | 16 | Output enable to the pads, 1 means drive |
| pad_in_i | input | 16 | Pin levels from the pads |

## Verification
The output latch is first loaded with a plain write and then changed through the set and clear aliases. Each alias gets one mask with 1 bits and one mask of all 0s, so a dropped bit, an inverted mask and a write that ignores the mask each give a different readback. Pin patterns are chosen to differ from the output latch, so the input view cannot be confused with the data register, and the bench reads them one and two cycles after a change to pin down the synchronizer depth. Write data with nonzero upper halves, stray offsets, and writes to the input view check that reserved bits and unmapped space do not leak into the state.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  parameter int unsigned GPIO_AW = 8;

  localparam logic [GPIO_AW-1:0] OFS_DIR  = 8'h10;
  localparam logic [GPIO_AW-1:0] OFS_DOUT = 8'h14;
  localparam logic [GPIO_AW-1:0] OFS_SET  = 8'h18;
  localparam logic [GPIO_AW-1:0] OFS_CLR  = 8'h1C;
  localparam logic [GPIO_AW-1:0] OFS_DIN  = 8'h20;

  typedef struct packed {
    logic dir;
    logic dout;
    logic set;
    logic clr;
    logic din;
  } gpio_sel_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] sync_o
);
  logic [STAGES-1:0][NPINS-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], pin_i};
  end

  assign sync_o = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      logic [1:0] settle_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               settle_q <= '0;
        else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
      end
      // R7
      sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (settle_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned AW = GPIO_AW
) (
  input  logic [AW-1:0] addr_i,
  output gpio_sel_t     sel_o,
  output logic          hit_o
);
  always_comb begin
    sel_o      = '0;
    sel_o.dir  = (addr_i == OFS_DIR);
    sel_o.dout = (addr_i == OFS_DOUT);
    sel_o.set  = (addr_i == OFS_SET);
    sel_o.clr  = (addr_i == OFS_CLR);
    sel_o.din  = (addr_i == OFS_DIN);
  end

  assign hit_o = |sel_o;
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  gpio_sel_t        sel_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] dout_o
);
  logic [NPINS-1:0] dir_q, dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      dout_q <= '0;
    end else if (we_i) begin
      if (sel_i.dir)  dir_q  <= wdata_i;
      if (sel_i.dout) dout_q <= wdata_i;
      if (sel_i.set)  dout_q <= dout_q | wdata_i;
      if (sel_i.clr)  dout_q <= dout_q & ~wdata_i;
    end
  end

  assign dir_o  = dir_q;
  assign dout_o = dout_q;

  // R4
  set_only_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i.set) |=>
      (((dout_q & $past(wdata_i)) == $past(wdata_i)) &&
       ((dout_q & ~$past(wdata_i)) == ($past(dout_q) & ~$past(wdata_i)))));

  // R5
  clr_only_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i.clr) |=>
      (((dout_q & $past(wdata_i)) == '0) &&
       ((dout_q & ~$past(wdata_i)) == ($past(dout_q) & ~$past(wdata_i)))));
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = GPIO_AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o,
  input  logic [NPINS-1:0] pad_in_i
);
  localparam int unsigned RSVD_W = DW - NPINS;

  gpio_sel_t        sel;
  logic             hit;
  logic [NPINS-1:0] dir_q, dout_q, din_sync;
  logic [NPINS-1:0] wdata_lo;
  logic [NPINS-1:0] rd_lo;
  logic             unused_wdata_hi;

  assign wdata_lo        = wdata_i[NPINS-1:0];
  assign unused_wdata_hi = ^wdata_i[DW-1:NPINS];

  gpio_addr_dec #(.AW(AW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  gpio_out_regs #(.NPINS(NPINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .sel_i   (sel),
    .wdata_i (wdata_lo),
    .dir_o   (dir_q),
    .dout_o  (dout_q)
  );

  gpio_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pad_in_i),
    .sync_o (din_sync)
  );

  always_comb begin
    rd_lo = '0;
    if (sel.dir)                rd_lo = dir_q;
    if (sel.dout || sel.set || sel.clr) rd_lo = dout_q;
    if (sel.din)                rd_lo = din_sync;
  end

  assign rdata_o   = {{RSVD_W{1'b0}}, rd_lo};
  assign pad_out_o = dout_q;
  assign pad_oe_o  = ~dir_q;

  // R6
  alias_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel.set || sel.clr) |-> (rdata_o[NPINS-1:0] == pad_out_o));

  // R8
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel.dir) |=> $stable(pad_oe_o));

  // R10
  stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (!hit || sel.din)) |=> ($stable(pad_out_o) && $stable(pad_oe_o)));
endmodule

// File: tb/gpio_regbank_bench.sv
module gpio_regbank_bench;
  localparam logic [7:0] A_DIR = 8'h10, A_OUT = 8'h14, A_SET = 8'h18,
                         A_CLR = 8'h1C, A_IN  = 8'h20;
  localparam int K_RD = 0, K_POUT = 1, K_POE = 2;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pad_out, pad_oe;
  logic [15:0] pins = '0;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  gpio_regbank u_gpio_regbank (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .pad_out_o (pad_out),
    .pad_oe_o  (pad_oe),
    .pad_in_i  (pins)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    it.kind = K_RD; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic chk_pad(input int k, input logic [15:0] e, input string t);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0;
    it.kind = k; it.exp = {16'h0, e}; it.tag = t;
    sb_q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_POUT:  act = {16'h0, pad_out};
          K_POE:   act = {16'h0, pad_oe};
          default: act = rdata;
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(A_DIR, 32'h0000FFFF, "R1 dir reset");
    rd(A_OUT, 32'h0, "R1 out reset");
    chk_pad(K_POE, 16'h0000, "R1 oe reset");
    // R2 direction and R9 upper bits
    wr(A_DIR, 32'hABCD00F0);
    rd(A_DIR, 32'h000000F0, "R2 R9 dir readback");
    chk_pad(K_POE, 16'hFF0F, "R2 oe inverse");
    // R3 output data
    wr(A_OUT, 32'h00001234);
    rd(A_OUT, 32'h00001234, "R3 out readback");
    chk_pad(K_POUT, 16'h1234, "R3 pad value");
    rd(A_IN, 32'h0, "R3 in view not latch");
    // R4 set alias
    wr(A_SET, 32'h00000101);
    rd(A_OUT, 32'h00001335, "R4 set ones");
    wr(A_SET, 32'h0);
    rd(A_OUT, 32'h00001335, "R4 set zeros");
    // R5 clear alias
    wr(A_CLR, 32'h00001004);
    rd(A_OUT, 32'h00000331, "R5 clr ones");
    wr(A_CLR, 32'h0);
    rd(A_OUT, 32'h00000331, "R5 clr zeros");
    // R6 alias readback
    rd(A_SET, 32'h00000331, "R6 set reads latch");
    rd(A_CLR, 32'h00000331, "R6 clr reads latch");
    // R7 two-cycle latency
    @(negedge clk);
    pins = 16'hA5A5;
    addr = A_IN;
    begin
      item_t it;
      it.kind = K_RD; it.exp = 32'h0; it.tag = "R7 same cycle";
      sb_q.push_back(it);
    end
    rd(A_IN, 32'h0, "R7 one edge");
    rd(A_IN, 32'h0000A5A5, "R7 two edges");
    rd(A_OUT, 32'h00000331, "R7 latch untouched by pins");
    // R8 input pins stay undriven
    wr(A_DIR, 32'h0000FFFF);
    wr(A_OUT, 32'h0000FFFF);
    wr(A_CLR, 32'h000000FF);
    wr(A_SET, 32'h00000F0F);
    chk_pad(K_POE, 16'h0000, "R8 oe stays low");
    rd(A_OUT, 32'h0000FF0F, "R8 latch still written");
    pins = 16'h3C3C;
    wr(A_DIR, 32'h0);
    chk_pad(K_POE, 16'hFFFF, "R2 all outputs");
    rd(A_IN, 32'h00003C3C, "R7 in view with outputs");
    // R9 reserved bits
    wr(A_OUT, 32'hFFFF0000);
    rd(A_OUT, 32'h0, "R9 upper write ignored");
    // R10 unmapped space
    wr(A_DIR, 32'h00000F0F);
    wr(A_OUT, 32'h00005A5A);
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h24, 32'h0);
    wr(A_IN, 32'h0);
    wr(8'h15, 32'hFFFFFFFF);
    rd(A_OUT, 32'h00005A5A, "R10 out unchanged");
    rd(A_DIR, 32'h00000F0F, "R10 dir unchanged");
    rd(8'h0C, 32'h0, "R10 read 0x0C");
    rd(8'h15, 32'h0, "R10 read 0x15");
    rd(8'h24, 32'h0, "R10 read 0x24");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule